// File: doc/BRIEF.md
# Indexed Control/Status Register Window

This block is the host-side slave of a network controller's register file. The host sees only four 16-bit offsets. It first writes a register number into a shared index latch. It then moves data through one of two data ports. One data port reaches the control/status bank and the other reaches the bus-configuration bank. Reading a dedicated offset resets the whole device state held here.

The control word at index 0 carries the command and status bits.
- Commands are set by writing them: initialise, start, stop and transmit-demand.
- Init-done is set by the ring engine when it finishes initialisation.
- The block turns commands into one-cycle pulses toward the ring engines.
- It holds the 32-bit init-block address in two halves.
- It returns a fixed 32-bit identification word across two indices.

Top module: `csr_window`

## Requirements
- R1: After reset the control word (index 0) reads 0x0004, meaning only STOP (bit 2) is set. The index latch reads 0. The outputs init_req_o, start_o, tx_demand_o, soft_rst_o and ib_addr_o are all zero.
- R2: The index port (offset 0x12) reads back the last value written to it, truncated to IDX_W bits. Writing 88 reads back 88. Writing 0xFFFF reads back 0x7F with IDX_W=7.
- R3: Indices 1 and 2 hold the low and high halves of the init-block address. Both read back what was written, and ib_addr_o equals {index2, index1}.
- R4: Indices 88 and 89 return the low and high halves of the identification word {4'h0, PART_CODE, 12'h003}. With the default part code this is 0xC003 and 0x01A5. Writes to these indices are ignored.
- R5: Writing bit 0 (INIT) of the control word sets INIT and clears STOP. It raises init_req_o for exactly the cycle after the write. INIT stays set until init_done_i arrives.
- R6: init_done_i sets bit 8 (init done) and clears INIT. Bit 8 stays set through writes with bit 8 at 0. Writing 1 to bit 8 clears it.
- R7: Writing bit 1 (START) sets START and clears STOP. It raises start_o for exactly the cycle after the write.
- R8: Writing bit 2 (STOP) clears START, INIT and transmit-demand and sets STOP. STOP overrides START or INIT written in the same word, and no start or init pulse is then produced.
- R9: Writing bit 3 (transmit demand) while STOP is clear sets bit 3 and raises tx_demand_o for exactly the cycle after the write. Bit 3 reads as 1 in that cycle only. While STOP is set the demand is ignored.
- R10: A read of offset 0x14 resets all state held here. Afterwards the control word is 0x0004, the index is 0, the init-block address is 0 and every configuration register is 0. soft_rst_o is high for the one cycle after that read.
- R11: The bus-configuration port (offset 0x16) reads and writes configuration register number index, using the same index latch. Indices at or above NUM_BCR ignore writes and read 0.
- R12: Control-bank indices other than 0, 1, 2, 88 and 89 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Access strobe, one access per cycle it is high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the window (0x10, 0x12, 0x14, 0x16) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational during a read access, 0 otherwise |
| init_done_i | input | 1 | Ring engine reports initialisation finished |
| init_req_o | output | 1 | One-cycle initialise request to the ring engine |
| start_o | output | 1 | One-cycle start request to the ring engines |
| tx_demand_o | output | 1 | One-cycle transmit poll request to the transmit engine |
| soft_rst_o | output | 1 | One-cycle pulse after a read of the reset offset |
| ib_addr_o | output | 32 | Init-block address {index2, index1} |

## Verification
A corrupted control word shows up at the ports within one cycle. A stuck or missing STOP changes the very next read of index 0, and it also decides whether a demand write yields a tx_demand_o pulse. A pulse that lasts too long shows up as a second high sample one cycle after the command. An index latch that drifts sends every later data access to the wrong register, so a readback of a known register exposes it at once. A soft reset that misses one register leaves a nonzero value that is visible on the first read after the reset offset is touched.

// File: rtl/csrw_pkg.sv
package csrw_pkg;
  // Window offsets (byte addresses)
  localparam logic [7:0] OFS_CSR_DATA  = 8'h10;
  localparam logic [7:0] OFS_INDEX     = 8'h12;
  localparam logic [7:0] OFS_RESET     = 8'h14;
  localparam logic [7:0] OFS_BCFG_DATA = 8'h16;

  // Control-bank indices with behaviour
  localparam int IDX_CTRL  = 0;
  localparam int IDX_IB_LO = 1;
  localparam int IDX_IB_HI = 2;
  localparam int IDX_ID_LO = 88;
  localparam int IDX_ID_HI = 89;

  // Control word bit positions
  localparam int B_INIT  = 0;
  localparam int B_START = 1;
  localparam int B_STOP  = 2;
  localparam int B_TDMD  = 3;
  localparam int B_IDONE = 8;

  localparam logic [11:0] ID_TAG = 12'h003;
endpackage

// File: rtl/csrw_index.sv
module csrw_index #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wdata_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q, idx_n;

  always_comb begin
    idx_n = idx_q;
    if (clr_i)     idx_n = '0;
    else if (we_i) idx_n = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_n;
  end

  assign idx_o = idx_q;

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (idx_q == $past(wdata_i)));
endmodule

// File: rtl/csrw_ctl.sv
module csrw_ctl
  import csrw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        we_i,
  input  logic        cmd_init_i,
  input  logic        cmd_start_i,
  input  logic        cmd_stop_i,
  input  logic        cmd_tdmd_i,
  input  logic        cmd_clr_done_i,
  input  logic        done_i,
  output logic [15:0] word_o,
  output logic        init_req_o,
  output logic        start_o,
  output logic        tx_demand_o
);
  logic init_q, start_q, stop_q, tdmd_q, done_q, ireq_q, spul_q;
  logic init_n, start_n, stop_n, tdmd_n, done_n, ireq_n, spul_n;

  always_comb begin
    init_n  = init_q;
    start_n = start_q;
    stop_n  = stop_q;
    done_n  = done_q;
    tdmd_n  = 1'b0;
    ireq_n  = 1'b0;
    spul_n  = 1'b0;
    if (clr_i) begin
      init_n  = 1'b0;
      start_n = 1'b0;
      stop_n  = 1'b1;
      done_n  = 1'b0;
    end else begin
      if (we_i && cmd_clr_done_i) done_n = 1'b0;
      if (done_i) begin
        done_n = 1'b1;
        init_n = 1'b0;
      end
      if (we_i && cmd_stop_i) begin
        init_n  = 1'b0;
        start_n = 1'b0;
        stop_n  = 1'b1;
      end else if (we_i) begin
        if (cmd_init_i) begin
          init_n = 1'b1;
          stop_n = 1'b0;
          ireq_n = 1'b1;
        end
        if (cmd_start_i) begin
          start_n = 1'b1;
          stop_n  = 1'b0;
          spul_n  = 1'b1;
        end
        if (cmd_tdmd_i && !tdmd_q && !stop_q) tdmd_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q  <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b1;
      tdmd_q  <= 1'b0;
      done_q  <= 1'b0;
      ireq_q  <= 1'b0;
      spul_q  <= 1'b0;
    end else begin
      init_q  <= init_n;
      start_q <= start_n;
      stop_q  <= stop_n;
      tdmd_q  <= tdmd_n;
      done_q  <= done_n;
      ireq_q  <= ireq_n;
      spul_q  <= spul_n;
    end
  end

  always_comb begin
    word_o          = '0;
    word_o[B_INIT]  = init_q;
    word_o[B_START] = start_q;
    word_o[B_STOP]  = stop_q;
    word_o[B_TDMD]  = tdmd_q;
    word_o[B_IDONE] = done_q;
  end

  assign init_req_o  = ireq_q;
  assign start_o     = spul_q;
  assign tx_demand_o = tdmd_q;

  // R5
  init_pulse_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ireq_q |-> !stop_q);
  // R9
  tdmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tdmd_q |=> !tdmd_q);
  // R8
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && cmd_stop_i) |=> (stop_q && !start_q && !init_q && !spul_q && !ireq_q));
  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(we_i && cmd_clr_done_i) && !clr_i) |=> done_q);
endmodule

// File: rtl/csrw_bcr_bank.sv
module csrw_bcr_bank #(
  parameter int NUM_BCR = 32,
  parameter int IDX_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      rdata_o
);
  logic [15:0] reg_q [NUM_BCR];

  for (genvar g = 0; g < NUM_BCR; g++) begin : g_reg
    logic        hit;
    logic [15:0] nxt;
    assign hit = we_i && (int'(idx_i) == g);
    always_comb begin
      nxt = reg_q[g];
      if (clr_i)    nxt = '0;
      else if (hit) nxt = wdata_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[g] <= '0;
      else        reg_q[g] <= nxt;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_BCR; i++)
      if (int'(idx_i) == i) rdata_o = reg_q[i];
  end

  // R10
  bcr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (reg_q[0] == 16'h0));
endmodule

// File: rtl/csr_window.sv
module csr_window
  import csrw_pkg::*;
#(
  parameter int          ADDR_W    = 5,
  parameter int          IDX_W     = 7,
  parameter int          NUM_BCR   = 32,
  parameter logic [15:0] PART_CODE = 16'h1A5C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              init_done_i,
  output logic              init_req_o,
  output logic              start_o,
  output logic              tx_demand_o,
  output logic              soft_rst_o,
  output logic [31:0]       ib_addr_o
);
  localparam logic [31:0] ID_WORD = {4'h0, PART_CODE, ID_TAG};

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_int = rsync_q[1];

  // Decode
  logic sel_csr, sel_idx, sel_rst, sel_bcfg;
  logic wr_csr, wr_idx, wr_bcfg, soft_clr;
  assign sel_csr  = bus_en && (bus_addr == ADDR_W'(OFS_CSR_DATA));
  assign sel_idx  = bus_en && (bus_addr == ADDR_W'(OFS_INDEX));
  assign sel_rst  = bus_en && (bus_addr == ADDR_W'(OFS_RESET));
  assign sel_bcfg = bus_en && (bus_addr == ADDR_W'(OFS_BCFG_DATA));
  assign wr_csr   = sel_csr  && bus_wr;
  assign wr_idx   = sel_idx  && bus_wr;
  assign wr_bcfg  = sel_bcfg && bus_wr;
  assign soft_clr = sel_rst  && !bus_wr;

  logic [IDX_W-1:0] idx;
  csrw_index #(.IDX_W(IDX_W)) u_index (
    .clk(clk), .rst_n(rst_n_int), .clr_i(soft_clr), .we_i(wr_idx),
    .wdata_i(bus_wdata[IDX_W-1:0]), .idx_o(idx)
  );

  logic at_ctrl, at_iblo, at_ibhi, at_idlo, at_idhi;
  assign at_ctrl = (idx == IDX_W'(IDX_CTRL));
  assign at_iblo = (idx == IDX_W'(IDX_IB_LO));
  assign at_ibhi = (idx == IDX_W'(IDX_IB_HI));
  assign at_idlo = (idx == IDX_W'(IDX_ID_LO));
  assign at_idhi = (idx == IDX_W'(IDX_ID_HI));

  logic [15:0] ctl_word;
  csrw_ctl u_ctl (
    .clk(clk), .rst_n(rst_n_int), .clr_i(soft_clr),
    .we_i(wr_csr && at_ctrl),
    .cmd_init_i(bus_wdata[B_INIT]), .cmd_start_i(bus_wdata[B_START]),
    .cmd_stop_i(bus_wdata[B_STOP]), .cmd_tdmd_i(bus_wdata[B_TDMD]),
    .cmd_clr_done_i(bus_wdata[B_IDONE]), .done_i(init_done_i),
    .word_o(ctl_word), .init_req_o(init_req_o), .start_o(start_o),
    .tx_demand_o(tx_demand_o)
  );

  logic [15:0] bcfg_rd;
  csrw_bcr_bank #(.NUM_BCR(NUM_BCR), .IDX_W(IDX_W)) u_bcr (
    .clk(clk), .rst_n(rst_n_int), .clr_i(soft_clr), .we_i(wr_bcfg),
    .idx_i(idx), .wdata_i(bus_wdata), .rdata_o(bcfg_rd)
  );

  // Init-block address halves
  logic [15:0] iblo_q, ibhi_q, iblo_n, ibhi_n;
  always_comb begin
    iblo_n = iblo_q;
    ibhi_n = ibhi_q;
    if (soft_clr) begin
      iblo_n = '0;
      ibhi_n = '0;
    end else begin
      if (wr_csr && at_iblo) iblo_n = bus_wdata;
      if (wr_csr && at_ibhi) ibhi_n = bus_wdata;
    end
  end

  logic srst_q;
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      iblo_q <= '0;
      ibhi_q <= '0;
      srst_q <= 1'b0;
    end else begin
      iblo_q <= iblo_n;
      ibhi_q <= ibhi_n;
      srst_q <= soft_clr;
    end
  end

  assign ib_addr_o  = {ibhi_q, iblo_q};
  assign soft_rst_o = srst_q;

  // Read path
  logic [15:0] csr_rd;
  always_comb begin
    csr_rd = '0;
    if (at_ctrl)      csr_rd = ctl_word;
    else if (at_iblo) csr_rd = iblo_q;
    else if (at_ibhi) csr_rd = ibhi_q;
    else if (at_idlo) csr_rd = ID_WORD[15:0];
    else if (at_idhi) csr_rd = ID_WORD[31:16];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_wr) begin
      if (sel_csr)       bus_rdata = csr_rd;
      else if (sel_idx)  bus_rdata = 16'(idx);
      else if (sel_bcfg) bus_rdata = bcfg_rd;
    end
  end

  // R10
  soft_rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    srst_q |-> (ctl_word == 16'h0004 && ib_addr_o == 32'h0));
  // R3
  ib_write_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_csr && at_iblo) |=> (ib_addr_o[15:0] == $past(bus_wdata)));
endmodule

// File: tb/csr_window_bench.sv
module csr_window_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_wr;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        init_done_i;
  logic        init_req_o, start_o, tx_demand_o, soft_rst_o;
  logic [31:0] ib_addr_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  csr_window u_csr_window (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .init_done_i(init_done_i), .init_req_o(init_req_o), .start_o(start_o),
    .tx_demand_o(tx_demand_o), .soft_rst_o(soft_rst_o), .ib_addr_o(ib_addr_o)
  );

  localparam logic [4:0] A_CSR = 5'h10, A_IDX = 5'h12, A_RST = 5'h14, A_BCF = 5'h16;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge.
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic csr_rd(input logic [15:0] i, output logic [15:0] d);
    wr(A_IDX, i);
    rd(A_CSR, d);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1 outputs", {init_req_o, start_o, tx_demand_o, soft_rst_o}, 0);
    chk("R1 ib_addr", ib_addr_o, 0);
    rd(A_IDX, d);  chk("R1 index", d, 0);
    rd(A_CSR, d);  chk("R1 ctrl word", d, 16'h0004);
  endtask

  task automatic t_index;
    logic [15:0] d;
    wr(A_IDX, 16'd88);   rd(A_IDX, d); chk("R2 index 88", d, 16'd88);
    wr(A_IDX, 16'hFFFF); rd(A_IDX, d); chk("R2 index truncated", d, 16'h007F);
  endtask

  task automatic t_id;
    logic [15:0] d;
    csr_rd(88, d); chk("R4 id low", d, 16'hC003);
    csr_rd(89, d); chk("R4 id high", d, 16'h01A5);
    wr(A_CSR, 16'h1234); rd(A_CSR, d); chk("R4 id write ignored", d, 16'h01A5);
  endtask

  task automatic t_ibaddr;
    logic [15:0] d;
    wr(A_IDX, 1); wr(A_CSR, 16'hBEE0);
    wr(A_IDX, 2); wr(A_CSR, 16'h0012);
    chk("R3 ib_addr", ib_addr_o, 32'h0012BEE0);
    csr_rd(1, d); chk("R3 low readback", d, 16'hBEE0);
    csr_rd(2, d); chk("R3 high readback", d, 16'h0012);
  endtask

  task automatic t_init;
    logic [15:0] d;
    wr(A_IDX, 0);
    wr(A_CSR, 16'h0001);
    chk("R5 init pulse", init_req_o, 1);
    rd(A_CSR, d); chk("R5 init set stop clear", d, 16'h0001);
    chk("R5 init pulse ends", init_req_o, 0);
    rd(A_CSR, d); chk("R5 init held", d, 16'h0001);
    init_done_i = 1'b1; @(negedge clk); init_done_i = 1'b0;
    rd(A_CSR, d); chk("R6 done set init cleared", d, 16'h0100);
    wr(A_CSR, 16'h0000); rd(A_CSR, d); chk("R6 done sticky", d, 16'h0100);
    wr(A_CSR, 16'h0100); rd(A_CSR, d); chk("R6 done cleared", d, 16'h0000);
  endtask

  task automatic t_start_tdmd;
    logic [15:0] d;
    wr(A_CSR, 16'h0002);
    chk("R7 start pulse", start_o, 1);
    rd(A_CSR, d); chk("R7 start set", d, 16'h0002);
    chk("R7 start pulse ends", start_o, 0);
    wr(A_CSR, 16'h0008);
    chk("R9 demand pulse", tx_demand_o, 1);
    rd(A_CSR, d); chk("R9 demand bit visible", d, 16'h000A);
    chk("R9 demand pulse ends", tx_demand_o, 0);
    rd(A_CSR, d); chk("R9 demand bit cleared", d, 16'h0002);
  endtask

  task automatic t_stop;
    logic [15:0] d;
    wr(A_CSR, 16'h0001);
    rd(A_CSR, d);
    wr(A_CSR, 16'h0006);
    chk("R8 no start pulse", start_o, 0);
    rd(A_CSR, d); chk("R8 stop wins", d, 16'h0004);
    wr(A_CSR, 16'h0008);
    chk("R9 demand ignored when stopped", tx_demand_o, 0);
    rd(A_CSR, d); chk("R9 word unchanged", d, 16'h0004);
  endtask

  task automatic t_unimpl;
    logic [15:0] d;
    wr(A_IDX, 80); wr(A_CSR, 16'h0C00);
    rd(A_CSR, d); chk("R12 unimplemented reads 0", d, 0);
    csr_rd(0, d); chk("R12 ctrl unchanged", d, 16'h0004);
  endtask

  task automatic t_bcfg;
    logic [15:0] d;
    wr(A_IDX, 20); wr(A_BCF, 16'h0002);
    wr(A_IDX, 18); wr(A_BCF, 16'h0800);
    rd(A_BCF, d); chk("R11 cfg 18", d, 16'h0800);
    wr(A_IDX, 40); wr(A_BCF, 16'hFFFF);
    rd(A_BCF, d); chk("R11 out of range reads 0", d, 0);
    wr(A_IDX, 20); rd(A_BCF, d); chk("R11 cfg 20", d, 16'h0002);
  endtask

  task automatic t_softreset;
    logic [15:0] d;
    wr(A_IDX, 0); wr(A_CSR, 16'h0002);
    rd(A_RST, d);
    chk("R10 soft reset pulse", soft_rst_o, 1);
    chk("R10 ib_addr cleared", ib_addr_o, 0);
    rd(A_IDX, d); chk("R10 index cleared", d, 0);
    chk("R10 pulse ends", soft_rst_o, 0);
    rd(A_CSR, d); chk("R10 ctrl word", d, 16'h0004);
    wr(A_IDX, 20); rd(A_BCF, d); chk("R10 cfg cleared", d, 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; init_done_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_index();
    t_id();
    t_ibaddr();
    t_init();
    t_start_tdmd();
    t_stop();
    t_unimpl();
    t_bcfg();
    t_softreset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule